// File: doc/BRIEF.md
# Four-Word Burst Quad-Data-Rate SRAM

This block is a synthesizable model of a static memory with a dedicated read data output and a dedicated write data input, so neither data path ever changes direction. One address bus serves both ports by time sharing. Each address selects a line of four words. A line moves as a four-beat burst on its port, and the read burst and the write burst may run at the same time.

`clk_i` runs at the beat rate, twice the rate of the K clock being modelled. One beat therefore stands for one half of K, and four beats make one frame. `beat_o` reports the current beat. In beat 0 the address bus and `rd_sel_ni` form the read slot. In beat 2 they form the write slot. Each slot is sampled on the rising edge of `clk_i` that ends its beat. Because of the frame, each port accepts at most one command every two K cycles, and its bursts never overlap.

`lat_mode_i` selects the read latency: one K cycle (two beats) or one and a half K cycles (three beats). A read that comes right after a write to the same line receives the new words, even though that write is still completing.

Top module: `qdr_burst_sram`

## Requirements
- R1: During reset and on the first beat after reset, `rvalid_o` is 0, `rdata_o` is 0 and `beat_o` is 0.
- R2: `beat_o` counts 0, 1, 2, 3 and then repeats. Beat 0 is the read slot and beat 2 is the write slot. A slot is sampled on the rising edge that ends its beat.
- R3: An accepted write takes `wdata_i` on four consecutive beats, starting with the write-slot beat (beats 2, 3, 0, 1). These words become words 0, 1, 2, 3 of the addressed line.
- R4: A read burst presents words 0, 1, 2, 3 of the line on four consecutive beats, with `rvalid_o` high on each of them. No low-order address bits choose a starting word.
- R5: Let E be the edge that samples the read slot. With `lat_mode_i`=0, word 0 is on the output after edge E+2. With `lat_mode_i`=1, word 0 is on the output after edge E+3.
- R6: Outside a read burst, `rvalid_o` is 0 and `rdata_o` is all zeros. Each accepted read gives exactly four valid beats.
- R7: A slot whose active-low select is high ignores the address bus. No burst starts, and write data presented during that frame changes no line.
- R8: A read in the frame after a write to the same line returns the newly written words.
- R9: A read and a write to different lines may share a frame. Reads in consecutive frames give gap-free back-to-back bursts.
- R10: A read whose slot comes before a write slot to the same line in the same frame returns the line's previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Beat clock, twice the K rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lat_mode_i | input | 1 | 1: three-beat read latency, 0: two-beat |
| addr_i | input | ADDR_W | Shared line address, read in beat 0 and write in beat 2 |
| rd_sel_ni | input | 1 | Read select, active low, sampled in beat 0 |
| wr_sel_ni | input | 1 | Write select, active low, sampled in beat 2 |
| wdata_i | input | DATA_W | Write data, one word per beat |
| rdata_o | output | DATA_W | Read data, one word per beat, zero when idle |
| rvalid_o | output | 1 | High on each read beat |
| beat_o | output | 2 | Current beat within the frame |

## Verification
The hardest case to reach is a read snapshot that falls on the same edge as the commit of a write to the same line. At that edge the last write word is still on `wdata_i` and has not reached the array. The bench reaches it by running a write frame and then, in the next frame, a read of that line. It also runs the mirror case, with the read slot ahead of a same-line write inside one frame. Back-to-back read frames mixed with writes to other lines test burst contiguity. Both latency modes are checked against exact arrival beats.

// File: rtl/qdr_pkg.sv
`timescale 1ns/1ps
package qdr_pkg;
  localparam int BURST_LEN = 4;
  localparam int CNT_W     = $clog2(BURST_LEN);

  typedef enum logic [1:0] {
    BEAT_RD   = 2'd0,
    BEAT_RD_N = 2'd1,
    BEAT_WR   = 2'd2,
    BEAT_WR_N = 2'd3
  } beat_e;
endpackage

// File: rtl/qdr_slot_ctrl.sv
`timescale 1ns/1ps
module qdr_slot_ctrl
  import qdr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  rd_sel_ni,
  input  logic  wr_sel_ni,
  output beat_e beat_o,
  output logic  rd_take_o,
  output logic  wr_take_o
);
  beat_e beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) beat_q <= BEAT_RD;
    else         beat_q <= beat_e'(2'(beat_q + 2'd1));
  end

  assign beat_o    = beat_q;
  assign rd_take_o = (beat_q == BEAT_RD) && !rd_sel_ni;
  assign wr_take_o = (beat_q == BEAT_WR) && !wr_sel_ni;
endmodule

// File: rtl/qdr_wr_stage.sv
`timescale 1ns/1ps
module qdr_wr_stage
  import qdr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 18
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  beat_e                               beat_i,
  input  logic                                wr_take_i,
  input  logic [ADDR_W-1:0]                   addr_i,
  input  logic [DATA_W-1:0]                   wdata_i,
  output logic                                commit_o,
  output logic [ADDR_W-1:0]                   commit_addr_o,
  output logic [BURST_LEN-1:0][DATA_W-1:0]    commit_line_o
);
  localparam int STAGED = BURST_LEN - 1;

  logic              active_q;
  logic [ADDR_W-1:0] waddr_q;
  logic [DATA_W-1:0] word_q [STAGED];
  logic [CNT_W-1:0]  word_idx;

  // write slot beat carries word 0
  assign word_idx = CNT_W'(beat_i + 2'd2);
  assign commit_o = active_q && (beat_i == BEAT_RD_N);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      waddr_q  <= '0;
    end else if (wr_take_i) begin
      active_q <= 1'b1;
      waddr_q  <= addr_i;
    end else if (commit_o) begin
      active_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if ((wr_take_i || active_q) && (int'(word_idx) < STAGED))
      word_q[word_idx] <= wdata_i;
  end

  generate
    for (genvar k = 0; k < STAGED; k++) begin : g_staged
      assign commit_line_o[k] = word_q[k];
    end
  endgenerate
  assign commit_line_o[BURST_LEN-1] = wdata_i;
  assign commit_addr_o              = waddr_q;

  a_r3_commit_after_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(wr_take_i, 3));
endmodule

// File: rtl/qdr_line_mem.sv
`timescale 1ns/1ps
module qdr_line_mem
  import qdr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 18
) (
  input  logic                             clk_i,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                waddr_i,
  input  logic [BURST_LEN-1:0][DATA_W-1:0] wline_i,
  input  logic [ADDR_W-1:0]                raddr_i,
  output logic [BURST_LEN-1:0][DATA_W-1:0] rline_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [BURST_LEN-1:0][DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wline_i;
  end

  // a line committing on this edge is forwarded to the reader
  always_comb begin
    if (we_i && (waddr_i == raddr_i)) rline_o = wline_i;
    else                              rline_o = mem_q[raddr_i];
  end
endmodule

// File: rtl/qdr_rd_pipe.sv
`timescale 1ns/1ps
module qdr_rd_pipe
  import qdr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 18
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  beat_e                            beat_i,
  input  logic                             lat_mode_i,
  input  logic                             rd_take_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [BURST_LEN-1:0][DATA_W-1:0] rline_i,
  output logic [ADDR_W-1:0]                raddr_o,
  output logic [DATA_W-1:0]                rdata_o,
  output logic                             rvalid_o
);
  logic                             pend_q;
  logic [ADDR_W-1:0]                raddr_q;
  logic [BURST_LEN-1:0][DATA_W-1:0] line_q;
  logic                             run_q;
  logic [CNT_W-1:0]                 cnt_q;
  logic [DATA_W-1:0]                p_q, d_q;
  logic                             p_v_q, d_v_q;
  logic                             load;

  assign load    = pend_q && (beat_i == BEAT_RD_N);
  assign raddr_o = raddr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      raddr_q <= '0;
    end else if (rd_take_i) begin
      pend_q  <= 1'b1;
      raddr_q <= addr_i;
    end else if (load) begin
      pend_q  <= 1'b0;
    end
  end

  // snapshot taken one beat after the read slot, after any prior-frame commit
  always_ff @(posedge clk_i) begin
    if (load) line_q <= rline_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      p_q   <= '0;
      p_v_q <= 1'b0;
      d_q   <= '0;
      d_v_q <= 1'b0;
    end else begin
      if (run_q) begin
        p_q   <= line_q[cnt_q];
        p_v_q <= 1'b1;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(BURST_LEN - 1)) run_q <= 1'b0;
      end else begin
        p_q   <= '0;
        p_v_q <= 1'b0;
      end
      if (load) begin
        run_q <= 1'b1;
        cnt_q <= '0;
      end
      d_q   <= p_q;
      d_v_q <= p_v_q;
    end
  end

  assign rdata_o  = lat_mode_i ? d_q   : p_q;
  assign rvalid_o = lat_mode_i ? d_v_q : p_v_q;

  a_r5_first_word_timing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_take_i |-> ##3 p_v_q);
  a_r6_four_valid_beats: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(p_v_q) |=> p_v_q ##1 p_v_q ##1 p_v_q);
  a_r9_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_take_i |-> !pend_q);
endmodule

// File: rtl/qdr_burst_sram.sv
`timescale 1ns/1ps
module qdr_burst_sram
  import qdr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lat_mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_sel_ni,
  input  logic              wr_sel_ni,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [1:0]        beat_o
);
  beat_e                            beat;
  logic                             rd_take, wr_take;
  logic                             commit;
  logic [ADDR_W-1:0]                commit_addr, raddr;
  logic [BURST_LEN-1:0][DATA_W-1:0] commit_line, rline;

  qdr_slot_ctrl u_slot (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_sel_ni (rd_sel_ni),
    .wr_sel_ni (wr_sel_ni),
    .beat_o    (beat),
    .rd_take_o (rd_take),
    .wr_take_o (wr_take)
  );

  qdr_wr_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .beat_i        (beat),
    .wr_take_i     (wr_take),
    .addr_i        (addr_i),
    .wdata_i       (wdata_i),
    .commit_o      (commit),
    .commit_addr_o (commit_addr),
    .commit_line_o (commit_line)
  );

  qdr_line_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i   (clk_i),
    .we_i    (commit),
    .waddr_i (commit_addr),
    .wline_i (commit_line),
    .raddr_i (raddr),
    .rline_o (rline)
  );

  qdr_rd_pipe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .beat_i     (beat),
    .lat_mode_i (lat_mode_i),
    .rd_take_i  (rd_take),
    .addr_i     (addr_i),
    .rline_i    (rline),
    .raddr_o    (raddr),
    .rdata_o    (rdata_o),
    .rvalid_o   (rvalid_o)
  );

  assign beat_o = beat;

  a_r6_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> (rdata_o == '0));
  a_r2_one_slot_per_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_take, wr_take, commit && wr_take}));
endmodule

// File: tb/qdr_burst_sram_bench.sv
`timescale 1ns/1ps
module qdr_burst_sram_bench;
  localparam int AW = 4;
  localparam int W  = 18;
  localparam int LW = 4 * W;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          lat_mode_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          rd_sel_ni = 1'b1;
  logic          wr_sel_ni = 1'b1;
  logic [W-1:0]  wdata_i = '0;
  logic [W-1:0]  rdata_o;
  logic          rvalid_o;
  logic [1:0]    beat_o;

  qdr_burst_sram #(.ADDR_W(AW), .DATA_W(W)) u_qdr_burst_sram (
    .clk_i(clk_i), .rst_ni(rst_ni), .lat_mode_i(lat_mode_i), .addr_i(addr_i),
    .rd_sel_ni(rd_sel_ni), .wr_sel_ni(wr_sel_ni), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o), .beat_o(beat_o)
  );

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  logic [LW-1:0] ref_mem [16];
  bit            wpend = 0;
  int            wpend_a = 0;
  logic [LW-1:0] wpend_l = '0;

  logic [W-1:0] exp_d [256];
  int           exp_c [256];
  int           en = 0;
  logic [W-1:0] got_d [256];
  int           got_c [256];
  int           gn = 0;
  int           idle_bad = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (rvalid_o === 1'b1) begin
        if (gn < 256) begin got_d[gn] = rdata_o; got_c[gn] = cyc; end
        gn++;
      end else if (rdata_o !== '0) idle_bad++;
    end
  end

  task automatic chk(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] mk(input int s);
    logic [LW-1:0] l;
    for (int k = 0; k < 4; k++) l[k*W +: W] = W'(s * 64 + k * 5 + 1);
    return l;
  endfunction

  task automatic wait_beat(input logic [1:0] b);
    @(negedge clk_i);
    while (beat_o != b) @(negedge clk_i);
  endtask

  // one frame: read slot in beat 0, write slot in beat 2
  task automatic frame(input bit rd, input int ra, input bit wr, input int wa,
                       input logic [LW-1:0] wl);
    int lat;
    wait_beat(2'd0);
    if (wpend) begin ref_mem[wpend_a] = wpend_l; end
    lat = lat_mode_i ? 3 : 2;
    rd_sel_ni = !rd;
    addr_i    = AW'(ra);
    wdata_i   = wpend ? wpend_l[2*W +: W] : W'(18'h2aaaa);
    if (rd) begin
      for (int k = 0; k < 4; k++) begin
        exp_d[en] = ref_mem[ra][k*W +: W];
        exp_c[en] = cyc + 1 + lat + k;
        en++;
      end
    end
    @(negedge clk_i);
    rd_sel_ni = 1'b1;
    addr_i    = AW'(wa);
    wdata_i   = wpend ? wpend_l[3*W +: W] : W'(18'h15555);
    wpend     = 0;
    @(negedge clk_i);
    wr_sel_ni = !wr;
    addr_i    = AW'(wa);
    wdata_i   = wl[0 +: W];
    if (wr) begin wpend = 1; wpend_a = wa; wpend_l = wl; end
    @(negedge clk_i);
    wr_sel_ni = 1'b1;
    wdata_i   = wl[W +: W];
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) frame(0, 0, 0, 0, '0);
  endtask

  task automatic check_reads(input string dreq, input string treq);
    chk("R6 beat count", LW'(gn), LW'(en));
    for (int i = 0; i < en && i < gn; i++) begin
      chk(dreq, LW'(got_d[i]), LW'(exp_d[i]));
      chk(treq, LW'(got_c[i]), LW'(exp_c[i]));
    end
    chk("R6 idle output zero", LW'(idle_bad), '0);
    gn = 0; en = 0; idle_bad = 0;
  endtask

  task automatic t_reset;
    #5;
    chk("R1 rvalid in reset", LW'(rvalid_o), '0);
    chk("R1 rdata in reset", LW'(rdata_o), '0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk("R1 beat after reset", LW'(beat_o), '0);
    chk("R1 rvalid after reset", LW'(rvalid_o), '0);
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk_i);
      chk("R2 beat sequence", LW'(beat_o), LW'(i % 4));
    end
  endtask

  task automatic t_basic_low;   // R3 R4 R5
    lat_mode_i = 1'b0;
    frame(0, 0, 1, 3, mk(1));
    frame(0, 0, 1, 6, mk(2));
    idle(1);
    frame(1, 3, 0, 0, '0);
    frame(1, 6, 0, 0, '0);
    idle(2);
    check_reads("R3 R4 word order", "R5 low latency");
  endtask

  task automatic t_forward;     // R8
    frame(0, 0, 1, 5, mk(3));
    frame(1, 5, 0, 0, '0);
    idle(2);
    check_reads("R8 forwarded data", "R5 forwarded timing");
  endtask

  task automatic t_same_frame_old;  // R10
    frame(1, 5, 1, 5, mk(4));
    frame(1, 5, 0, 0, '0);
    idle(2);
    check_reads("R10 read before same-frame write", "R10 timing");
  endtask

  task automatic t_concurrent;  // R9
    frame(1, 3, 1, 7, mk(5));
    frame(1, 5, 1, 8, mk(6));
    frame(1, 7, 1, 9, mk(7));
    frame(1, 8, 0, 0, '0);
    frame(1, 9, 0, 0, '0);
    idle(2);
    check_reads("R9 concurrent data", "R9 back-to-back timing");
  endtask

  task automatic t_deselect;    // R7
    frame(0, 3, 0, 3, mk(9));
    idle(2);
    chk("R7 no burst when deselected", LW'(gn), '0);
    frame(1, 3, 0, 0, '0);
    idle(2);
    check_reads("R7 line unchanged", "R7 timing");
  endtask

  task automatic t_high;        // R5 high mode
    lat_mode_i = 1'b1;
    frame(1, 5, 0, 0, '0);
    frame(1, 7, 1, 5, mk(10));
    frame(1, 5, 0, 0, '0);
    idle(3);
    check_reads("R5 high mode data", "R5 high latency");
    lat_mode_i = 1'b0;
  endtask

  initial begin
    t_reset();
    t_basic_low();
    t_forward();
    t_same_frame_old();
    t_concurrent();
    t_deselect();
    t_high();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule